// File: doc/BRIEF.md
# Run-Time Indexed Stream Read Unit

This unit performs a processor read from one of several AXI4-Stream slave links. The link is chosen at run time from the low four bits of a register operand. An index at or above the configured link count falls back to link 0. The unit returns the link's data word for the destination register, reports a carry update in non-blocking mode and reports a sticky stream-error update. It can also raise either a privileged-instruction exception or a stream exception. A stream exception carries the index and the data word.

An operation starts with a one-cycle `op_start` pulse, together with the mode bits, the user-mode flag and the index. When the selected link has a word, or when the read is non-blocking, the unit decides in that same cycle. In that cycle it pulses TREADY on the selected link if a word is taken. The result outputs follow one cycle later, or two cycles later when the area-optimized pipeline is chosen. A blocking read with no data waits and raises `stall`. It leaves the wait when data arrives. It also leaves the wait, with an abort pulse, when an interrupt request arrives and the atomic bit is clear.

Top module: `stream_get_unit`

## Requirements
- R1: With `user_mode` high at `op_start`, no link is read. A completion is reported with `exc_valid` high and `exc_code` = 5'b00111. `rd_we`, `carry_we` and `serr_set` stay low, and every TREADY bit stays low.
- R2: The link used is `idx_operand` when that value is below `N_LINKS`. Otherwise link 0 is used.
- R3: On a completion without an exception, `rd_we` is high and `rd_data` equals the selected link's TDATA. `rd_we` is low whenever `exc_valid` is high.
- R4: A non-blocking read always completes at once. `carry_we` is high and `carry_val` equals the selected link's TVALID. With no data present the read still completes, and no word is taken.
- R5: When the selected link has TVALID high and its TLAST differs from `op_ctrl`, `serr_set` pulses with the result.
- R6: When `op_exc_en` is set and R5 applies, a stream exception is raised. `exc_valid` goes high with `exc_code` = 5'b00000, `exc_ess` carries the unclamped 4-bit `idx_operand`, and `exc_data` carries the TDATA. No word is taken.
- R7: With `STREAM_EXC` = 0, `op_exc_en` has no effect: a mismatching word is taken and written like any other word.
- R8: A blocking read with no data holds `stall` high from the cycle after `op_start`, and no TREADY is raised. The results appear 1 cycle after the handshake cycle with `AREA_OPT` = 0, and 2 cycles after it with `AREA_OPT` = 1.
- R9: During a blocking wait, `irq_req` with `op_atomic` clear ends the wait. It does so with an `op_abort` pulse, no `op_done` and no word taken. With `op_atomic` set, the wait continues.
- R10: TREADY is high for one cycle, on the selected link only and only while that link's TVALID is high. It is never high when an exception is raised or when a non-blocking read finds no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle strobe that starts a read |
| op_nonblock | input | 1 | Non-blocking mode |
| op_ctrl | input | 1 | Expected TLAST value |
| op_exc_en | input | 1 | Raise a stream exception on a control mismatch |
| op_atomic | input | 1 | A blocking wait ignores interrupt requests |
| user_mode | input | 1 | Processor is in user mode |
| idx_operand | input | 4 | Low bits of the link index register |
| irq_req | input | 1 | Pending interrupt request |
| s_tdata | input | N_LINKS*DATA_W | TDATA of all links, link k at bits k*DATA_W upward |
| s_tvalid | input | N_LINKS | TVALID per link |
| s_tlast | input | N_LINKS | TLAST per link |
| s_tready | output | N_LINKS | TREADY per link |
| stall | output | 1 | Blocking wait in progress |
| op_done | output | 1 | Read completed |
| op_abort | output | 1 | Blocking wait abandoned for an interrupt |
| rd_we | output | 1 | Destination register write enable |
| rd_data | output | DATA_W | Destination register value |
| carry_we | output | 1 | Carry flag write enable |
| carry_val | output | 1 | Carry flag value |
| serr_set | output | 1 | Set the sticky stream-error flag |
| exc_valid | output | 1 | Exception raised |
| exc_code | output | 5 | Exception code |
| exc_ess | output | 4 | Exception status: link index |
| exc_data | output | DATA_W | Exception data word |

## Verification
Directed reads cover these cases: a matching word, an empty non-blocking link, an out-of-range index, a TLAST mismatch with and without the exception enable, and user mode. Each case separates write, carry, error-flag and exception behaviour. Blocking reads are tried with data already present and with data arriving after several stalled cycles. Interrupts are tried with the atomic bit clear and set, which separates an abandoned wait from a continued one. Two instances run in parallel: one with exceptions on and a 1-cycle result, one with exceptions off and a 2-cycle result. The same stimulus therefore also separates R7 and the latency variants. A final run of random valid, last and data patterns is compared against a reference model.

// File: rtl/sget_pkg.sv
package sget_pkg;

    localparam logic [4:0] EC_PRIV   = 5'b00111;
    localparam logic [4:0] EC_STREAM = 5'b00000;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } sget_state_e;

    typedef struct packed {
        logic       done;
        logic       abort;
        logic       rd_we;
        logic       carry_we;
        logic       carry_val;
        logic       serr_set;
        logic       exc_valid;
        logic [4:0] exc_code;
        logic [3:0] exc_ess;
    } sget_flags_t;

    function automatic logic [3:0] clamp_link(input logic [3:0] raw, input int unsigned n);
        return (32'(raw) >= n) ? 4'd0 : raw;
    endfunction

endpackage

// File: rtl/sget_link_mux.sv
module sget_link_mux #(
    parameter int N_LINKS = 4,
    parameter int DATA_W  = 32
) (
    input  logic [N_LINKS*DATA_W-1:0] s_tdata,
    input  logic [N_LINKS-1:0]        s_tvalid,
    input  logic [N_LINKS-1:0]        s_tlast,
    input  logic [3:0]                sel,
    output logic                      link_v,
    output logic                      link_l,
    output logic [DATA_W-1:0]         link_d
);
    logic [DATA_W-1:0] words [N_LINKS];

    for (genvar k = 0; k < N_LINKS; k++) begin : g_word
        assign words[k] = s_tdata[k*DATA_W +: DATA_W];
    end

    always_comb begin
        link_v = 1'b0;
        link_l = 1'b0;
        link_d = '0;
        for (int k = 0; k < N_LINKS; k++) begin
            if (sel == 4'(k)) begin
                link_v = s_tvalid[k];
                link_l = s_tlast[k];
                link_d = words[k];
            end
        end
    end
endmodule

// File: rtl/sget_ctrl.sv
module sget_ctrl
    import sget_pkg::*;
#(
    parameter int N_LINKS    = 4,
    parameter int STREAM_EXC = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        op_start,
    input  logic        op_nonblock,
    input  logic        op_ctrl,
    input  logic        op_exc_en,
    input  logic        op_atomic,
    input  logic        user_mode,
    input  logic [3:0]  idx_operand,
    input  logic        irq_req,
    input  logic        link_v,
    input  logic        link_l,
    output logic [3:0]  sel,
    output logic        fire,
    output logic        stall,
    output sget_flags_t flags
);
    localparam bit EXC_ON = (STREAM_EXC != 0);

    sget_state_e state_q;
    logic        nb_q, ctrl_q, exc_q, atomic_q;
    logic [3:0]  idx_q;

    logic       start_new, in_wait, active, priv, mism, exc, complete, abort, go_wait;
    logic       cur_nb, cur_ctrl, cur_exc;
    logic [3:0] cur_idx;

    always_comb begin
        start_new = (state_q == ST_IDLE) && op_start;
        in_wait   = (state_q == ST_WAIT);
        cur_idx   = in_wait ? idx_q  : idx_operand;
        cur_nb    = in_wait ? nb_q   : op_nonblock;
        cur_ctrl  = in_wait ? ctrl_q : op_ctrl;
        cur_exc   = in_wait ? exc_q  : op_exc_en;
        sel       = clamp_link(cur_idx, N_LINKS);

        priv     = start_new && user_mode;
        active   = (start_new && !user_mode) || in_wait;
        mism     = link_v && (link_l != cur_ctrl);
        exc      = active && mism && cur_exc && EXC_ON;
        complete = active && (link_v || cur_nb);
        fire     = active && link_v && !exc;
        go_wait  = start_new && !user_mode && !op_nonblock && !link_v;
        abort    = in_wait && !link_v && irq_req && !atomic_q;

        flags.done      = priv || complete;
        flags.abort     = abort;
        flags.rd_we     = complete && !exc;
        flags.carry_we  = complete && cur_nb;
        flags.carry_val = link_v;
        flags.serr_set  = active && mism;
        flags.exc_valid = priv || exc;
        flags.exc_code  = priv ? EC_PRIV : EC_STREAM;
        flags.exc_ess   = cur_idx;
    end

    assign stall = in_wait;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            nb_q     <= 1'b0;
            ctrl_q   <= 1'b0;
            exc_q    <= 1'b0;
            atomic_q <= 1'b0;
            idx_q    <= '0;
        end else begin
            if (start_new) begin
                nb_q     <= op_nonblock;
                ctrl_q   <= op_ctrl;
                exc_q    <= op_exc_en;
                atomic_q <= op_atomic;
                idx_q    <= idx_operand;
            end
            if (go_wait) begin
                state_q <= ST_WAIT;
            end else if (in_wait && (link_v || abort)) begin
                state_q <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/sget_result_pipe.sv
module sget_result_pipe
    import sget_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  sget_flags_t       flags_in,
    input  logic [DATA_W-1:0] data_in,
    output sget_flags_t       flags_out,
    output logic [DATA_W-1:0] data_out
);
    sget_flags_t       f_q [STAGES];
    logic [DATA_W-1:0] d_q [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    f_q[k] <= '0;
                    d_q[k] <= '0;
                end else begin
                    f_q[k] <= flags_in;
                    d_q[k] <= data_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    f_q[k] <= '0;
                    d_q[k] <= '0;
                end else begin
                    f_q[k] <= f_q[k-1];
                    d_q[k] <= d_q[k-1];
                end
            end
        end
    end

    assign flags_out = f_q[STAGES-1];
    assign data_out  = d_q[STAGES-1];
endmodule

// File: rtl/stream_get_unit.sv
module stream_get_unit
    import sget_pkg::*;
#(
    parameter int N_LINKS    = 4,
    parameter int DATA_W     = 32,
    parameter int STREAM_EXC = 1,
    parameter int AREA_OPT   = 0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      op_start,
    input  logic                      op_nonblock,
    input  logic                      op_ctrl,
    input  logic                      op_exc_en,
    input  logic                      op_atomic,
    input  logic                      user_mode,
    input  logic [3:0]                idx_operand,
    input  logic                      irq_req,
    input  logic [N_LINKS*DATA_W-1:0] s_tdata,
    input  logic [N_LINKS-1:0]        s_tvalid,
    input  logic [N_LINKS-1:0]        s_tlast,
    output logic [N_LINKS-1:0]        s_tready,
    output logic                      stall,
    output logic                      op_done,
    output logic                      op_abort,
    output logic                      rd_we,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      carry_we,
    output logic                      carry_val,
    output logic                      serr_set,
    output logic                      exc_valid,
    output logic [4:0]                exc_code,
    output logic [3:0]                exc_ess,
    output logic [DATA_W-1:0]         exc_data
);
    localparam int STAGES = (AREA_OPT != 0) ? 2 : 1;

    logic [3:0]        sel;
    logic              link_v, link_l, fire;
    logic [DATA_W-1:0] link_d, res_d;
    sget_flags_t       flags_c, flags_r;

    sget_link_mux #(.N_LINKS(N_LINKS), .DATA_W(DATA_W)) u_mux (
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
        .sel(sel), .link_v(link_v), .link_l(link_l), .link_d(link_d)
    );

    sget_ctrl #(.N_LINKS(N_LINKS), .STREAM_EXC(STREAM_EXC)) u_ctrl (
        .clk(clk), .rst(rst), .op_start(op_start), .op_nonblock(op_nonblock),
        .op_ctrl(op_ctrl), .op_exc_en(op_exc_en), .op_atomic(op_atomic),
        .user_mode(user_mode), .idx_operand(idx_operand), .irq_req(irq_req),
        .link_v(link_v), .link_l(link_l), .sel(sel), .fire(fire),
        .stall(stall), .flags(flags_c)
    );

    sget_result_pipe #(.DATA_W(DATA_W), .STAGES(STAGES)) u_pipe (
        .clk(clk), .rst(rst), .flags_in(flags_c), .data_in(link_d),
        .flags_out(flags_r), .data_out(res_d)
    );

    always_comb begin
        s_tready = '0;
        for (int k = 0; k < N_LINKS; k++) begin
            if (fire && (sel == 4'(k))) s_tready[k] = 1'b1;
        end
    end

    assign op_done   = flags_r.done;
    assign op_abort  = flags_r.abort;
    assign rd_we     = flags_r.rd_we;
    assign rd_data   = res_d;
    assign carry_we  = flags_r.carry_we;
    assign carry_val = flags_r.carry_val;
    assign serr_set  = flags_r.serr_set;
    assign exc_valid = flags_r.exc_valid;
    assign exc_code  = flags_r.exc_code;
    assign exc_ess   = flags_r.exc_ess;
    assign exc_data  = res_d;
endmodule

// File: rtl/stream_get_chk.sv
module stream_get_chk #(
    parameter int N_LINKS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [N_LINKS-1:0] s_tvalid,
    input logic [N_LINKS-1:0] s_tready,
    input logic               rd_we,
    input logic               carry_we,
    input logic               serr_set,
    input logic               exc_valid,
    input logic [4:0]         exc_code
);
    assert_ready_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_tready));

    assert_ready_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
        (s_tready & ~s_tvalid) == '0);

    assert_exc_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> !rd_we);

    assert_priv_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exc_code == 5'b00111) |-> (!carry_we && !serr_set));

    assert_stream_exc_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exc_code == 5'b00000) |-> serr_set);
endmodule

bind stream_get_unit stream_get_chk #(.N_LINKS(N_LINKS)) u_chk (
    .clk(clk), .rst(rst), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .rd_we(rd_we), .carry_we(carry_we), .serr_set(serr_set),
    .exc_valid(exc_valid), .exc_code(exc_code)
);

// File: tb/test_stream_get_unit.sv
module test_stream_get_unit;
    localparam int NL = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          op_start = 0, op_nonblock = 0, op_ctrl = 0, op_exc_en = 0, op_atomic = 0;
    logic          user_mode = 0, irq_req = 0;
    logic [3:0]    idx_operand = 0;
    logic [DW-1:0] tdat [NL];
    logic [NL-1:0] vld = '0, lst = '0;
    logic [NL*DW-1:0] s_tdata;

    always_comb for (int k = 0; k < NL; k++) s_tdata[k*DW +: DW] = tdat[k];

    logic [NL-1:0] a_rdy, b_rdy;
    logic a_stall, a_done, a_abort, a_rwe, a_cwe, a_cv, a_serr, a_exc;
    logic b_stall, b_done, b_abort, b_rwe, b_cwe, b_cv, b_serr, b_exc;
    logic [4:0] a_code, b_code;
    logic [3:0] a_ess, b_ess;
    logic [DW-1:0] a_rd, a_exd, b_rd, b_exd;

    stream_get_unit #(.N_LINKS(NL), .DATA_W(DW), .STREAM_EXC(1), .AREA_OPT(0)) i_stream_get_unit (
        .clk(clk), .rst(rst), .op_start(op_start), .op_nonblock(op_nonblock), .op_ctrl(op_ctrl),
        .op_exc_en(op_exc_en), .op_atomic(op_atomic), .user_mode(user_mode),
        .idx_operand(idx_operand), .irq_req(irq_req), .s_tdata(s_tdata), .s_tvalid(vld),
        .s_tlast(lst), .s_tready(a_rdy), .stall(a_stall), .op_done(a_done), .op_abort(a_abort),
        .rd_we(a_rwe), .rd_data(a_rd), .carry_we(a_cwe), .carry_val(a_cv), .serr_set(a_serr),
        .exc_valid(a_exc), .exc_code(a_code), .exc_ess(a_ess), .exc_data(a_exd)
    );

    stream_get_unit #(.N_LINKS(NL), .DATA_W(DW), .STREAM_EXC(0), .AREA_OPT(1)) i_stream_get_unit_b (
        .clk(clk), .rst(rst), .op_start(op_start), .op_nonblock(op_nonblock), .op_ctrl(op_ctrl),
        .op_exc_en(op_exc_en), .op_atomic(op_atomic), .user_mode(user_mode),
        .idx_operand(idx_operand), .irq_req(irq_req), .s_tdata(s_tdata), .s_tvalid(vld),
        .s_tlast(lst), .s_tready(b_rdy), .stall(b_stall), .op_done(b_done), .op_abort(b_abort),
        .rd_we(b_rwe), .rd_data(b_rd), .carry_we(b_cwe), .carry_val(b_cv), .serr_set(b_serr),
        .exc_valid(b_exc), .exc_code(b_code), .exc_ess(b_ess), .exc_data(b_exd)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] ref_sel(input logic [3:0] idx);
        return (32'(idx) < NL) ? idx : 4'd0;
    endfunction

    // Reference flags {done,abort,rd_we,carry_we,carry_val,serr,exc,code[5],ess[4]}
    function automatic logic [15:0] ref_flags(input logic usr, nb, ctl, een, exc_on, input logic [3:0] idx);
        logic [3:0] s = ref_sel(idx);
        logic v = vld[s];
        logic mism = v && (lst[s] != ctl);
        logic priv = usr;
        logic ex = !priv && mism && een && exc_on;
        logic cpl = !priv && (v || nb);
        logic anyx = priv || ex;
        return {priv || cpl, 1'b0, cpl && !ex, cpl && nb, cpl && nb && v, !priv && mism, anyx,
                anyx ? (priv ? 5'b00111 : 5'b00000) : 5'b0, anyx ? idx : 4'b0};
    endfunction

    function automatic logic [31:0] ref_data(input logic usr, nb, ctl, een, exc_on, input logic [3:0] idx);
        logic [3:0] s = ref_sel(idx);
        logic v = vld[s];
        logic ex = !usr && v && (lst[s] != ctl) && een && exc_on;
        return (!usr && (v || nb)) || ex ? tdat[s] : 32'h0;
    endfunction

    function automatic logic [31:0] ref_ready(input logic usr, ctl, een, exc_on, input logic [3:0] idx);
        logic [3:0] s = ref_sel(idx);
        logic v = vld[s];
        logic ex = v && (lst[s] != ctl) && een && exc_on;
        return (!usr && v && !ex) ? (32'd1 << s) : 32'd0;
    endfunction

    function automatic logic [15:0] act_a();
        return {a_done, a_abort, a_rwe, a_cwe, a_cwe & a_cv, a_serr, a_exc,
                a_exc ? a_code : 5'b0, a_exc ? a_ess : 4'b0};
    endfunction
    function automatic logic [15:0] act_b();
        return {b_done, b_abort, b_rwe, b_cwe, b_cwe & b_cv, b_serr, b_exc,
                b_exc ? b_code : 5'b0, b_exc ? b_ess : 4'b0};
    endfunction
    function automatic logic [31:0] dat_a();
        return a_rwe ? a_rd : (a_exc && a_code == 5'b0) ? a_exd : 32'h0;
    endfunction
    function automatic logic [31:0] dat_b();
        return b_rwe ? b_rd : (b_exc && b_code == 5'b0) ? b_exd : 32'h0;
    endfunction

    // One read that decides in its start cycle; entered and left at a negedge.
    task automatic run_op(input string req, input logic usr, nb, ctl, een, input logic [3:0] idx);
        logic [15:0] fa, fb;
        logic [31:0] da, db;
        fa = ref_flags(usr, nb, ctl, een, 1'b1, idx);
        fb = ref_flags(usr, nb, ctl, een, 1'b0, idx);
        da = ref_data(usr, nb, ctl, een, 1'b1, idx);
        db = ref_data(usr, nb, ctl, een, 1'b0, idx);
        user_mode = usr; op_nonblock = nb; op_ctrl = ctl; op_exc_en = een;
        idx_operand = idx; op_start = 1'b1;
        #1;
        check({req, " R10 ready A"}, 32'(a_rdy), ref_ready(usr, ctl, een, 1'b1, idx));
        check({req, " R10 ready B"}, 32'(b_rdy), ref_ready(usr, ctl, een, 1'b0, idx));
        @(posedge clk); @(negedge clk);
        op_start = 1'b0; user_mode = 1'b0;
        check({req, " flags A"}, 32'(act_a()), 32'(fa));
        check({req, " data A"}, dat_a(), da);
        check({req, " R8 B not yet"}, 32'(b_done), 32'd0);
        @(posedge clk); @(negedge clk);
        check({req, " R7 flags B"}, 32'(act_b()), 32'(fb));
        check({req, " R7 data B"}, dat_b(), db);
        check({req, " A quiet"}, 32'(a_done), 32'd0);
    endtask

    task automatic setup_links();
        for (int k = 0; k < NL; k++) tdat[k] = 32'hC0DE_0000 + 32'(k * 32'h111);
        vld = '0; lst = '0;
    endtask

    task automatic t_reset();
        check("R10 reset ready A", 32'(a_rdy), 0);
        check("R8 reset stall", 32'({a_stall, b_stall}), 0);
        check("R3 reset outputs", 32'(act_a()), 0);
        check("R3 reset outputs B", 32'(act_b()), 0);
    endtask

    task automatic t_nonblock();
        setup_links();
        vld[2] = 1; lst[2] = 1;
        run_op("R3 R4 nb present", 0, 1, 1, 0, 4'd2);
        vld = '0;
        run_op("R4 R10 nb empty", 0, 1, 0, 0, 4'd1);
    endtask

    task automatic t_clamp();
        setup_links();
        vld = '1;
        run_op("R2 idx 7 clamps", 0, 1, 0, 0, 4'd7);
        run_op("R2 idx 15 clamps", 0, 0, 0, 0, 4'd15);
        run_op("R2 idx 4 top link", 0, 1, 0, 0, 4'd4);
    endtask

    task automatic t_mismatch();
        setup_links();
        vld[3] = 1; lst[3] = 1;
        run_op("R5 R6 R7 mism exc", 0, 0, 0, 1, 4'd3);
        run_op("R5 mism noexc", 0, 1, 0, 0, 4'd3);
        vld = '1; lst[0] = 1;
        run_op("R6 ess raw idx 9", 0, 1, 0, 1, 4'd9);
    endtask

    task automatic t_user();
        setup_links();
        vld = '1;
        run_op("R1 user mode", 1, 1, 0, 1, 4'd2);
        run_op("R1 user blocking", 1, 0, 1, 0, 4'd0);
    endtask

    task automatic t_block_wait();
        setup_links();
        user_mode = 0; op_nonblock = 0; op_ctrl = 0; op_exc_en = 0; op_atomic = 0;
        idx_operand = 4'd2; op_start = 1;
        #1;
        check("R8 no ready empty", 32'({a_rdy, b_rdy}), 0);
        @(posedge clk); @(negedge clk);
        op_start = 0;
        for (int c = 0; c < 3; c++) begin
            check("R8 stall held", 32'({a_stall, b_stall}), 32'd3);
            check("R8 no ready while stalled", 32'({a_rdy, b_rdy}), 0);
            check("R8 no done while stalled", 32'({a_done, b_done}), 0);
            @(posedge clk); @(negedge clk);
        end
        vld[2] = 1; lst[2] = 0;
        #1;
        check("R8 R10 ready on arrival", 32'({a_rdy, b_rdy}), 32'({5'b00100, 5'b00100}));
        @(posedge clk); @(negedge clk);
        vld = '0;
        check("R8 A result 1 cycle", 32'({a_done, a_rwe, a_stall}), 32'b110);
        check("R3 A rd data", a_rd, tdat[2]);
        check("R8 B not yet", 32'(b_done), 0);
        @(posedge clk); @(negedge clk);
        check("R8 B result 2 cycles", 32'({b_done, b_rwe}), 32'b11);
        check("R3 B rd data", b_rd, tdat[2]);
    endtask

    task automatic t_irq();
        setup_links();
        op_nonblock = 0; op_ctrl = 0; op_atomic = 0; idx_operand = 4'd1; op_start = 1;
        @(posedge clk); @(negedge clk);
        op_start = 0; irq_req = 1;
        #1;
        check("R9 no ready on abort", 32'({a_rdy, b_rdy}), 0);
        @(posedge clk); @(negedge clk);
        irq_req = 0;
        check("R9 A abort", 32'({a_abort, a_done, a_stall}), 32'b100);
        @(posedge clk); @(negedge clk);
        check("R9 B abort", 32'({b_abort, b_done, b_stall}), 32'b100);
        op_atomic = 1; op_start = 1;
        @(posedge clk); @(negedge clk);
        op_start = 0; irq_req = 1;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); @(negedge clk);
            check("R9 atomic keeps waiting", 32'({a_stall, a_abort, b_abort}), 32'b100);
        end
        irq_req = 0; vld[1] = 1;
        @(posedge clk); @(negedge clk);
        vld = '0; op_atomic = 0;
        check("R9 atomic completes", 32'({a_done, a_rwe, a_abort}), 32'b110);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_random();
        for (int i = 0; i < 40; i++) begin
            logic nb, usr;
            logic [3:0] idx;
            for (int k = 0; k < NL; k++) tdat[k] = $urandom;
            vld = NL'($urandom); lst = NL'($urandom);
            nb = 1'($urandom); usr = ($urandom % 8) == 0; idx = 4'($urandom);
            if (!nb) vld[ref_sel(idx)] = 1'b1;
            run_op("R2 R3 R4 R5 R6 random", usr, nb, 1'($urandom), 1'($urandom), idx);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        setup_links();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_nonblock();
        t_clamp();
        t_mismatch();
        t_user();
        t_block_wait();
        t_irq();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule